// File: doc/BRIEF.md
# LUT-based dynamic range compressor

This block conditions a 22-bit signed sample stream for output. Each sample arrives with two flags that mark an upstream positive or negative overflow. A prescaler shifts the sample right so that a chosen 8-bit window can address a 64-entry table of 32-bit words. The table also holds two saturation words. These replace the normal entry when the sample overflowed, or when the window cannot represent the sample without losing significant bits.

Each table word holds a signed shift amount and a 22-bit offset. The sample is scaled by a rounding shifter, and the offset is then added, so the output is input times scale plus offset, with the scale and offset chosen per segment. Two overlay switches can also place one byte of the table word onto the low and/or high byte of the result. This allows plain 8-bit to 8-bit mappings.

A byte-wide host port loads and reads the table, but only while the table is switched out of the datapath. The datapath is a two-stage pipeline, and a valid strobe travels alongside each sample.

Top module: `drc_lut_path`

## Requirements
- R1: A sample accepted with `in_valid` appears on `out_data` with `out_valid` high exactly two clock cycles later. Synchronous reset clears `out_valid` and `out_data` to zero.
- R2: The table index is the low 8 bits of X arithmetically shifted right by `cfg_prescale`. Values above 16 act as 16. Index bits 7:2 pick the word, and index bits 1:0 pick the output byte, where byte k is word bits 8k+7:8k.
- R3: The window is out of range when any bit of the shifted value above bit 7 differs from bit 7. If X bit 21 is 0 this is an over-select, which reads the upper saturation word. If X bit 21 is 1 it is an under-select, which reads the lower saturation word.
- R4: The saturation word is chosen in this priority order: `x_ovf_pos`, which gives the upper word; then `x_ovf_neg`, which gives the lower word; then the over-select or under-select. Any override forces byte 3 to be selected.
- R5: While `cfg_table_en` is 0, the table word is taken as zero and the normaliser uses `cfg_static_shift`.
- R6: The normaliser shift is a 5-bit two's complement value s. For 1..14 the output is (X + 2^(s-1)) arithmetically shifted right by s. For 0 the output is X. For -1 and -2 it is X shifted left by 1 or 2 places with no rounding, truncated to 22 bits. Any other value gives zero.
- R7: With `cfg_table_en` and `cfg_dyn_en` both 1, the shift is taken from table word bits 26:22 instead of the static field.
- R8: The output adds the normaliser result to table word bits 21:0 when `cfg_offset_en` is 1, or to zero otherwise. The add is 22-bit and wraps.
- R9: `cfg_byte_lo_en` replaces output bits 7:0 with the selected byte, and `cfg_byte_hi_en` replaces bits 21:14 with it. The two act independently, and the other bits keep the sum.
- R10: Host byte address 4n+k holds byte k of word n (n = 0..63). Addresses 256..259 hold the upper saturation word and 260..263 the lower one. A read returns the byte on `host_rdata` in the cycle after the request.
- R11: While `cfg_table_en` is 1, host writes change nothing and host reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| x_in | input | 22 | Signed sample |
| x_ovf_pos | input | 1 | Sample overflowed positively |
| x_ovf_neg | input | 1 | Sample overflowed negatively |
| cfg_prescale | input | 5 | Prescaler right-shift amount |
| cfg_table_en | input | 1 | Table in datapath (1) or host-accessible (0) |
| cfg_dyn_en | input | 1 | Shift from table word bits 26:22 |
| cfg_static_shift | input | 5 | Static signed normaliser shift |
| cfg_offset_en | input | 1 | Add table bits 21:0 |
| cfg_byte_lo_en | input | 1 | Overlay selected byte on bits 7:0 |
| cfg_byte_hi_en | input | 1 | Overlay selected byte on bits 21:14 |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 9 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| out_valid | output | 1 | Result strobe |
| out_data | output | 22 | Result |

## Verification
The point where two functions meet is the case where an upstream overflow flag and a prescaler window miss occur on the same sample. The bench provokes it by driving X large enough that the window is out of range while also raising a flag of the opposite polarity, and by raising both flags together. Each result is judged against an independent model: it must carry the saturation word chosen by the flag, not the one chosen by the window, and byte 3 must appear in any active overlay. Randomised runs over many configurations mix these collisions with ordinary table hits.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    SRC_TBL = 2'd0,
    SRC_UP  = 2'd1,
    SRC_LO  = 2'd2
  } drc_src_e;
endpackage

// File: rtl/drc_prescale.sv
module drc_prescale #(
  parameter int XW      = 22,
  parameter int IDX_W   = 8,
  parameter int PRE_W   = 5,
  parameter int MAX_PRE = 16
) (
  input  logic [XW-1:0]    x,
  input  logic [PRE_W-1:0] amt,
  output logic [IDX_W-1:0] idx,
  output logic             over_sel,
  output logic             under_sel
);
  localparam int HI_W = XW - IDX_W + 1;

  logic [PRE_W-1:0]     amt_c;
  logic signed [XW-1:0] xs;
  logic [HI_W-1:0]      hi;
  logic                 miss;

  always_comb begin
    amt_c     = (amt > PRE_W'(MAX_PRE)) ? PRE_W'(MAX_PRE) : amt;
    xs        = $signed(x) >>> amt_c;
    idx       = xs[IDX_W-1:0];
    hi        = xs[XW-1:IDX_W-1];
    miss      = !((&hi) || !(|hi));
    over_sel  = miss && !x[XW-1];
    under_sel = miss && x[XW-1];
  end
endmodule

// File: rtl/drc_table.sv
module drc_table #(
  parameter int AW    = 7,
  parameter int DEPTH = 66,
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     lock,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]               wdata,
  output logic [LANES*8-1:0]       q
);
  localparam int LW = $clog2(LANES);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q_lane;
    always_ff @(posedge clk) begin
      if (we && lane == LW'(g)) mem[addr] <= wdata;
      q_lane <= mem[addr];
    end
    assign q[g*8 +: 8] = q_lane;
  end

  assert_locked_write_R11: assert property (@(posedge clk) disable iff (rst)
    lock |-> !we);
endmodule

// File: rtl/drc_normalise.sv
module drc_normalise #(
  parameter int XW    = 22,
  parameter int SH_W  = 5,
  parameter int MAX_R = 14,
  parameter int MAX_L = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XW-1:0]   x,
  input  logic [SH_W-1:0] shift,
  output logic [XW-1:0]   y
);
  localparam int EW = XW + 2;

  logic signed [SH_W-1:0] s;
  int                     sa;
  logic signed [EW-1:0]   xe, rnd, sum, shr;
  logic                   oor;

  always_comb begin
    s   = $signed(shift);
    sa  = int'(s);
    xe  = EW'($signed(x));
    rnd = '0;
    sum = '0;
    shr = '0;
    oor = (sa > MAX_R) || (sa < -MAX_L);
    y   = '0;
    if (sa == 0) begin
      y = x;
    end else if (sa > 0 && sa <= MAX_R) begin
      rnd = EW'(1) << (sa - 1);
      sum = xe + rnd;
      shr = sum >>> sa;
      y   = shr[XW-1:0];
    end else if (!oor) begin
      y = x << (-sa);
    end
  end

  assert_oor_zero_R6: assert property (@(posedge clk) disable iff (rst)
    oor |-> (y == '0));
endmodule

// File: rtl/drc_lut_path.sv
module drc_lut_path
  import drc_pkg::*;
#(
  parameter int XW      = 22,
  parameter int IDX_W   = 8,
  parameter int WORD_W  = 32,
  parameter int SH_W    = 5,
  parameter int PRE_W   = 5,
  parameter int MAX_PRE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XW-1:0]    x_in,
  input  logic             x_ovf_pos,
  input  logic             x_ovf_neg,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic             cfg_table_en,
  input  logic             cfg_dyn_en,
  input  logic [SH_W-1:0]  cfg_static_shift,
  input  logic             cfg_offset_en,
  input  logic             cfg_byte_lo_en,
  input  logic             cfg_byte_hi_en,
  input  logic             host_en,
  input  logic             host_we,
  input  logic [IDX_W:0]   host_addr,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  output logic             out_valid,
  output logic [XW-1:0]    out_data
);
  localparam int WSEL_W = IDX_W - 2;
  localparam int NWORDS = 2 ** WSEL_W;
  localparam int TAW    = WSEL_W + 1;
  localparam int LANES  = WORD_W / 8;
  localparam int BSEL_W = $clog2(LANES);

  // stage 0: prescale and source choice
  logic [IDX_W-1:0]  idx;
  logic              over_sel, under_sel;
  drc_src_e          src;
  logic [TAW-1:0]    dp_addr, host_word, mem_addr;
  logic [BSEL_W-1:0] bsel0;
  logic              host_ok, host_wr;

  drc_prescale #(.XW(XW), .IDX_W(IDX_W), .PRE_W(PRE_W), .MAX_PRE(MAX_PRE)) u_pre (
    .x(x_in), .amt(cfg_prescale), .idx(idx),
    .over_sel(over_sel), .under_sel(under_sel)
  );

  always_comb begin
    if (x_ovf_pos)      src = SRC_UP;
    else if (x_ovf_neg) src = SRC_LO;
    else if (over_sel)  src = SRC_UP;
    else if (under_sel) src = SRC_LO;
    else                src = SRC_TBL;
    case (src)
      SRC_UP:  dp_addr = TAW'(NWORDS);
      SRC_LO:  dp_addr = TAW'(NWORDS + 1);
      default: dp_addr = {1'b0, idx[IDX_W-1:BSEL_W]};
    endcase
    bsel0 = (src == SRC_TBL) ? idx[BSEL_W-1:0] : '1;
    if (host_addr[IDX_W]) begin
      host_ok   = (host_addr[IDX_W-1:BSEL_W+1] == '0);
      host_word = TAW'(NWORDS) + TAW'(host_addr[BSEL_W]);
    end else begin
      host_ok   = 1'b1;
      host_word = {1'b0, host_addr[IDX_W-1:BSEL_W]};
    end
    host_wr  = host_en && host_we && host_ok && !cfg_table_en;
    mem_addr = cfg_table_en ? dp_addr : host_word;
  end

  logic [WORD_W-1:0] q;
  drc_table #(.AW(TAW), .DEPTH(NWORDS + 2), .LANES(LANES)) u_tbl (
    .clk(clk), .rst(rst), .lock(cfg_table_en), .we(host_wr), .addr(mem_addr),
    .lane(host_addr[BSEL_W-1:0]), .wdata(host_wdata), .q(q)
  );

  // stage 1 registers
  logic              v1, rd_ok;
  logic [XW-1:0]     x1;
  logic [BSEL_W-1:0] bsel1, rd_lane;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1    <= 1'b0;
      rd_ok <= 1'b0;
    end else begin
      v1    <= in_valid;
      rd_ok <= host_en && !host_we && host_ok && !cfg_table_en;
    end
    x1      <= x_in;
    bsel1   <= bsel0;
    rd_lane <= host_addr[BSEL_W-1:0];
  end

  assign host_rdata = rd_ok ? q[{rd_lane, 3'b000} +: 8] : 8'h00;

  // stage 2: normalise, offset, overlay
  logic [WORD_W-1:0] word;
  logic [SH_W-1:0]   shift;
  logic [XW-1:0]     norm, sum, res;
  logic [7:0]        sel_byte;

  always_comb begin
    word     = cfg_table_en ? q : '0;
    shift    = (cfg_table_en && cfg_dyn_en) ? word[XW+SH_W-1:XW] : cfg_static_shift;
    sel_byte = word[{bsel1, 3'b000} +: 8];
  end

  drc_normalise #(.XW(XW), .SH_W(SH_W)) u_norm (
    .clk(clk), .rst(rst), .x(x1), .shift(shift), .y(norm)
  );

  always_comb begin
    sum = norm + (cfg_offset_en ? word[XW-1:0] : '0);
    res = sum;
    if (cfg_byte_lo_en) res[7:0] = sel_byte;
    if (cfg_byte_hi_en) res[XW-1:XW-8] = sel_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v1;
      out_data  <= res;
    end
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  assert_idle_latency_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  assert_ovf_byte3_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (x_ovf_pos || x_ovf_neg)) |=> (bsel1 == '1));
  assert_locked_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (host_en && cfg_table_en) |=> (host_rdata == 8'h00));
endmodule

// File: tb/drc_lut_path_tb.sv
module drc_lut_path_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1;
  logic        in_valid = 0, x_ovf_pos = 0, x_ovf_neg = 0;
  logic [21:0] x_in = '0;
  logic [4:0]  cfg_prescale = '0, cfg_static_shift = '0;
  logic        cfg_table_en = 0, cfg_dyn_en = 0, cfg_offset_en = 0;
  logic        cfg_byte_lo_en = 0, cfg_byte_hi_en = 0;
  logic        host_en = 0, host_we = 0;
  logic [8:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic        out_valid;
  logic [21:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  drc_lut_path u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
    .x_ovf_pos(x_ovf_pos), .x_ovf_neg(x_ovf_neg), .cfg_prescale(cfg_prescale),
    .cfg_table_en(cfg_table_en), .cfg_dyn_en(cfg_dyn_en),
    .cfg_static_shift(cfg_static_shift), .cfg_offset_en(cfg_offset_en),
    .cfg_byte_lo_en(cfg_byte_lo_en), .cfg_byte_hi_en(cfg_byte_hi_en),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct { logic [21:0] v; string tag; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] shadow [66];
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] model(input logic [21:0] x, input logic p, input logic n);
    longint xs, hi, v, nv;
    int pre, w, b, s;
    logic [31:0] word;
    logic [7:0] byt;
    logic [21:0] r;
    pre = (cfg_prescale > 16) ? 16 : int'(cfg_prescale);
    xs  = longint'($signed(x)) >>> pre;
    hi  = xs >>> 7;
    b   = 3;
    if (p) w = 64;
    else if (n) w = 65;
    else if (!(hi == 0 || hi == -1)) w = x[21] ? 65 : 64;
    else begin w = int'(xs[7:2]); b = int'(xs[1:0]); end
    word = cfg_table_en ? shadow[w] : 32'h0;
    s    = (cfg_table_en && cfg_dyn_en) ? int'($signed(word[26:22])) : int'($signed(cfg_static_shift));
    v    = longint'($signed(x));
    if (s == 0) nv = v;
    else if (s >= 1 && s <= 14) nv = (v + (longint'(1) << (s-1))) >>> s;
    else if (s == -1 || s == -2) nv = v * (longint'(1) << (-s));
    else nv = 0;
    r   = 22'(nv) + (cfg_offset_en ? word[21:0] : 22'h0);
    byt = 8'(word >> (8*b));
    if (cfg_byte_lo_en) r[7:0] = byt;
    if (cfg_byte_hi_en) r[21:14] = byt;
    return r;
  endfunction

  task automatic send(input logic [21:0] x, input logic p, input logic n, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1; x_in = x; x_ovf_pos = p; x_ovf_neg = n;
    e.v = model(x, p, n); e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 0; x_ovf_pos = 0; x_ovf_neg = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hwr(input int a, input logic [7:0] d);
    int w;
    @(negedge clk);
    host_en = 1; host_we = 1; host_addr = 9'(a); host_wdata = d;
    if (!cfg_table_en) begin
      w = (a < 256) ? a / 4 : 64 + ((a / 4) & 1);
      shadow[w][8*(a%4) +: 8] = d;
    end
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic hrd(input int a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_en = 1; host_we = 0; host_addr = 9'(a);
    @(negedge clk);
    chk(host_rdata == exp, tag, host_rdata, exp);
    host_en = 0;
  endtask

  task automatic setcfg(input int pre, input int sh, input bit te, dy, of, lo, hi);
    cfg_prescale = 5'(pre); cfg_static_shift = 5'(sh); cfg_table_en = te;
    cfg_dyn_en = dy; cfg_offset_en = of; cfg_byte_lo_en = lo; cfg_byte_hi_en = hi;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) chk(0, "R1 unexpected out_valid", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_data == e.v, e.tag, out_data, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 66; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0 && out_data == 0, "R1 reset state", {out_valid, out_data}, 0);

    // table switched out: pass-through and static shifts
    setcfg(0, 0, 0, 1, 1, 0, 0);
    send(22'h012345, 0, 0, "R5 pass-through");
    send(22'h3ABCDE, 1, 0, "R5 flags with table off");
    send(22'h1FFFFF, 0, 1, "R5 flags with table off");
    drain();
    setcfg(0, 0, 0, 0, 0, 0, 1);
    send(22'h00ABCD, 0, 0, "R9 high overlay of zero word");
    drain();
    setcfg(0, 2, 0, 0, 0, 0, 0);
    send(22'(-3), 0, 0, "R6 right 2 round negative");
    send(22'd6, 0, 0, "R6 right 2 round up");
    send(22'd5, 0, 0, "R6 right 2 round down");
    drain();
    setcfg(0, 14, 0, 0, 0, 0, 0);
    send(22'h1FFFFF, 0, 0, "R6 right 14");
    drain();
    setcfg(0, 5'b11110, 0, 0, 0, 0, 0);
    send(22'd3, 0, 0, "R6 left 2");
    send(22'h180000, 0, 0, "R6 left 2 wraps");
    drain();
    setcfg(0, 5'b11111, 0, 0, 0, 0, 0);
    send(22'(-7), 0, 0, "R6 left 1");
    drain();
    setcfg(0, 15, 0, 0, 0, 0, 0);
    send(22'h001234, 0, 0, "R6 shift 15 zero");
    drain();
    setcfg(0, 5'b11101, 0, 0, 0, 0, 0);
    send(22'h001234, 0, 0, "R6 shift -3 zero");
    drain();

    // load the table through the host port
    for (int a = 0; a < 264; a++) begin
      logic [31:0] h;
      h = 32'(a / 4) * 32'h9E3779B1 ^ 32'h5A5A1234;
      hwr(a, h[8*(a%4) +: 8]);
    end
    hrd(0, shadow[0][7:0], "R10 word 0 byte 0");
    hrd(19, shadow[4][31:24], "R10 word 4 byte 3");
    hrd(254, shadow[63][23:16], "R10 word 63 byte 2");
    hrd(259, shadow[64][31:24], "R10 upper saturation byte 3");
    hrd(260, shadow[65][7:0], "R10 lower saturation byte 0");

    // table enabled: lock checks
    setcfg(4, 0, 1, 1, 1, 1, 0);
    hwr(5, ~shadow[1][15:8]);
    hrd(5, 8'h00, "R11 locked read zero");

    send(22'h000123, 0, 0, "R2 R7 R8 table hit");
    send(22'h0000FF, 0, 0, "R2 edge of window");
    send(22'h001000, 0, 0, "R3 over-select");
    send(22'h3FF000, 0, 0, "R3 under-select");
    send(22'h3FFF80, 0, 0, "R3 negative in range");
    send(22'h001000, 0, 1, "R4 neg flag beats over-select");
    send(22'h3FF000, 1, 0, "R4 pos flag beats under-select");
    send(22'h000010, 1, 1, "R4 both flags pick upper");
    drain();
    setcfg(31, 0, 1, 1, 0, 1, 1);
    send(22'h2ABCDE, 0, 0, "R2 prescale clamp");
    send(22'h001000, 0, 1, "R9 R4 overlays carry byte 3");
    drain();
    setcfg(16, 0, 1, 0, 1, 0, 1);
    send(22'h1FFFFF, 0, 0, "R8 R9 static shift with offset");
    drain();

    for (int m = 0; m < 10; m++) begin
      int cb;
      cb = int'($urandom);
      setcfg(int'($urandom % 20), int'($urandom % 32), cb[0] | cb[5], cb[1], cb[2], cb[3], cb[4]);
      for (int k = 0; k < 120; k++) begin
        logic [21:0] xr;
        xr = 22'($urandom) >> ($urandom % 16);
        send(xr, ($urandom % 12) == 0, ($urandom % 12) == 0, "R2 R3 R4 R6 R7 R8 R9 random");
      end
      drain();
    end

    setcfg(0, 0, 0, 0, 0, 0, 0);
    hrd(5, shadow[1][15:8], "R11 locked write had no effect");
    drain();
    chk(exp_q.size() == 0, "R1 missing outputs", exp_q.size(), 0);
    finish_run();
  end
endmodule